// File: doc/BRIEF.md
# Page-Mode Flash Burst Reader

This block sits on the host side of an asynchronous parallel NOR flash that supports page-mode reads. A requester hands it a starting word address and a word count. The block then drives the chip-select, output-enable and write-enable strobes and the word address bus. It captures each 16-bit word from the flash data input and delivers the words, in address order, on a valid/ready output stream.

The flash groups words into pages of four that share every address bit above the lowest two. The first word fetched after a page is opened must wait the full random-access time. Each following word inside the same page only waits the much shorter page-access time. The block counts both delays in clock cycles, derived from nanosecond parameters and rounded up. It picks the long or the short delay for each word by checking whether the address stepped into a new page.

A captured word sits in a one-entry holding register until the consumer takes it. While that register is full, the address and the strobes are frozen. Between bursts the device is deselected.

Top module: `flash_page_reader`

## Requirements
- R1: After reset, chip-select and output-enable are high (inactive), write-enable is high, `out_valid` is low and `req_ready` is high.
- R2: The first word of every burst is captured ACC = ceil(TACC_NS / CLK_PERIOD_NS) cycles after the cycle in which the request was accepted. This holds even when the previous burst read the same page.
- R3: A word whose address shares bits [21:2] with the previous word of the same burst is captured PACC = ceil(TPACC_NS / CLK_PERIOD_NS) cycles after the previous capture.
- R4: Inside a burst, a word whose address has bits [1:0] equal to 00 opens a new page and waits ACC cycles after the previous capture. This includes the wrap from address 0x3FFFFF to 0x000000.
- R5: A burst of N words delivers exactly N words, holding the flash data at addresses start, start+1, … (modulo 2^22) in that order.
- R6: Chip-select and output-enable are both low from the cycle after acceptance until the last word is captured. Both are high in the cycle the last word first appears on the output, and they stay high while idle.
- R7: Write-enable stays high at all times.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` stays stable, no word is lost, and the flash address does not change.
- R9: A request with a count of zero is accepted and then ignored: the device stays deselected and no word is produced.
- R10: `req_ready` is high only while no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 22 | Word address of the first word |
| req_len | input | 8 | Number of words to read |
| flash_ce_n | output | 1 | Flash chip select, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, held high |
| flash_addr | output | 22 | Flash word address |
| flash_dq | input | 16 | Flash data bus (input side) |
| out_valid | output | 1 | Captured word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Captured word |

## Verification
A wait counter loaded with the wrong value or at the wrong time shows in the very word it governs. Either that word is captured from a bus that is not yet valid, and the wrong data appears on `out_data`, or the word arrives on a cycle other than the ACC/PACC spacing measured from acceptance or from the previous word. A broken address counter or page check shows within one word as wrong data or wrong spacing. A control state that fails to return to idle shows at the last word as strobes still low and `req_ready` still low. Stall handling errors show during the stall itself as a moving address or changing output data.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,  // waiting the full random-access time
        ST_INPG  = 2'd2   // waiting the short in-page time
    } fpr_state_e;

    function automatic int cycles_ceil(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fpr_wait_timer.sv
`timescale 1ns/1ps
module fpr_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fpr_hold_reg.sv
`timescale 1ns/1ps
module fpr_hold_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (in_valid) begin
            slot_d.full = 1'b1;
            slot_d.word = in_data;
        end else if (out_ready) begin
            slot_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign in_ready  = !slot_q.full || out_ready;
    assign out_valid = slot_q.full;
    assign out_data  = slot_q.word;
endmodule

// File: rtl/flash_page_reader.sv
`timescale 1ns/1ps
module flash_page_reader
    import fpr_pkg::*;
#(
    parameter int ADDR_W        = 22,
    parameter int DATA_W        = 16,
    parameter int LEN_W         = 8,
    parameter int PAGE_WORDS    = 4,
    parameter int CLK_PERIOD_NS = 8,
    parameter int TACC_NS       = 90,
    parameter int TPACC_NS      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic [DATA_W-1:0] flash_dq,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int PAGE_BITS = $clog2(PAGE_WORDS);
    localparam int ACC_CYC   = cycles_ceil(TACC_NS, CLK_PERIOD_NS);
    localparam int PACC_CYC  = cycles_ceil(TPACC_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC   = (ACC_CYC > PACC_CYC) ? ACC_CYC : PACC_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ACC_LOAD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] PACC_LOAD = CNT_W'(PACC_CYC - 1);

    typedef struct packed {
        fpr_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             capture;
    logic             slot_free;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = ctl_q.addr + ADDR_W'(1);

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = ACC_LOAD;
        capture  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid && req_len != '0) begin
                    ctl_d.state = ST_OPEN;
                    ctl_d.addr  = req_addr;
                    ctl_d.left  = req_len;
                    tmr_load    = 1'b1;
                    tmr_val     = ACC_LOAD;
                end
            end
            ST_OPEN, ST_INPG: begin
                if (tmr_done && slot_free) begin
                    capture = 1'b1;
                    if (ctl_q.left == LEN_W'(1)) begin
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.left = ctl_q.left - LEN_W'(1);
                        ctl_d.addr = next_addr;
                        tmr_load   = 1'b1;
                        if (next_addr[PAGE_BITS-1:0] == '0) begin
                            ctl_d.state = ST_OPEN;
                            tmr_val     = ACC_LOAD;
                        end else begin
                            ctl_d.state = ST_INPG;
                            tmr_val     = PACC_LOAD;
                        end
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.addr  <= '0;
            ctl_q.left  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fpr_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    fpr_hold_reg #(.DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (capture),
        .in_data   (flash_dq),
        .in_ready  (slot_free),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign flash_ce_n = (ctl_q.state == ST_IDLE);
    assign flash_oe_n = (ctl_q.state == ST_IDLE);
    assign flash_we_n = 1'b1;
    assign flash_addr = ctl_q.addr;
endmodule

// File: rtl/flash_page_reader_chk.sv
`timescale 1ns/1ps
module flash_page_reader_chk #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              flash_ce_n,
    input logic              flash_oe_n,
    input logic              flash_we_n,
    input logic [ADDR_W-1:0] flash_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    AST_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        flash_we_n); // R7

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && flash_oe_n)); // R10

    AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ce_n == flash_oe_n); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flash_ce_n) |=> $stable(flash_addr)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && !$past(flash_ce_n) && flash_addr != $past(flash_addr))
        |-> flash_addr == $past(flash_addr) + ADDR_W'(1)); // R5
endmodule

bind flash_page_reader flash_page_reader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/flash_page_reader_tb_top.sv
`timescale 1ns/1ps
module flash_page_reader_tb_top;
    localparam int CLK_NS   = 8;
    localparam int TACC     = 90;
    localparam int TPACC    = 25;
    localparam int ACC_EXP  = (TACC + CLK_NS - 1) / CLK_NS;
    localparam int PACC_EXP = (TPACC + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        flash_ce_n, flash_oe_n, flash_we_n;
    logic [21:0] flash_addr;
    logic [15:0] dq_drv = 16'hDEAD;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;

    int cyc = 0;
    int total = 0;
    int fails = 0;
    int we_bad = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_page_reader #(
        .CLK_PERIOD_NS(CLK_NS), .TACC_NS(TACC), .TPACC_NS(TPACC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_addr(flash_addr), .flash_dq(dq_drv),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [15:0] pat(input logic [21:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {10'b0, a[21:16]};
    endfunction

    // Flash model: data becomes valid only after the access time has elapsed.
    int          seq = 0;
    logic        pg_open = 1'b0;
    logic [19:0] pg_tag = '0;
    realtime     open_t = 0;

    task automatic settle(input int s, input logic [21:0] a, input int n);
        #(n);
        if (s == seq) dq_drv = pat(a);
    endtask

    always @(flash_addr or flash_ce_n or flash_oe_n) begin
        int need;
        seq = seq + 1;
        dq_drv = 16'hDEAD;
        if (flash_ce_n === 1'b0 && flash_oe_n === 1'b0) begin
            if (!pg_open) begin
                pg_open = 1'b1;
                open_t  = $realtime;
            end
            need = (pg_tag == flash_addr[21:2] && open_t != $realtime) ? TPACC : TACC;
            if (pg_tag != flash_addr[21:2]) open_t = $realtime - 1;
            pg_tag = flash_addr[21:2];
            fork
                settle(seq, flash_addr, need);
            join_none
        end else begin
            pg_open = 1'b0;
        end
    end

    always @(negedge clk) if (rst_n && flash_we_n !== 1'b1) we_bad++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Generic burst with optional stall on one word.
    task automatic run_burst(input logic [21:0] a, input int len,
                             input int stall_idx, input int stall_len);
        int got = 0;
        int guard = 0;
        int t0, last;
        bit stalled = 0;
        logic [21:0] snap;
        logic [15:0] held;
        bit stall_ok;
        @(negedge clk);
        req_addr = a; req_len = len[7:0]; req_valid = 1'b1; out_ready = 1'b1;
        check(req_ready == 1'b1, "R10", "ready before accept", req_ready, 1);
        t0 = cyc + 1;
        last = t0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready during burst", req_ready, 0);
        check(!flash_ce_n && !flash_oe_n, "R6", "strobes low in burst",
              {flash_ce_n, flash_oe_n}, 0);
        while (got < len && guard < 3000) begin
            guard++;
            if (stall_idx == got && out_valid && !stalled) begin
                stalled = 1;
                out_ready = 1'b0;
                snap = flash_addr;
                held = out_data;
                stall_ok = 1;
                for (int k = 0; k < stall_len; k++) begin
                    @(negedge clk);
                    if (!out_valid || out_data != held || flash_addr != snap || flash_ce_n)
                        stall_ok = 0;
                end
                check(stall_ok, "R8", "frozen during stall", stall_ok, 1);
                out_ready = 1'b1;
            end
            if (out_valid && out_ready) begin
                logic [21:0] ea;
                int expg;
                ea = a + 22'(got);
                check(out_data == pat(ea), "R5", "word data", out_data, pat(ea));
                if (stall_idx < 0) begin
                    if (got == 0) begin
                        check(cyc - last == ACC_EXP, "R2", "first word latency", cyc - last, ACC_EXP);
                    end else if (ea[1:0] == 2'b00) begin
                        check(cyc - last == ACC_EXP, "R4", "page cross latency", cyc - last, ACC_EXP);
                    end else begin
                        expg = PACC_EXP;
                        check(cyc - last == expg, "R3", "in-page latency", cyc - last, expg);
                    end
                end
                last = cyc;
                if (got == len - 1)
                    check(flash_ce_n && flash_oe_n && req_ready, "R6", "deselect at last word",
                          {flash_ce_n, flash_oe_n, req_ready}, 3'b111);
                got++;
            end
            @(negedge clk);
        end
        check(got == len, "R5", "word count", got, len);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(flash_ce_n && flash_oe_n && flash_we_n, "R1", "strobes after reset",
              {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        check(!out_valid && req_ready, "R1", "handshake after reset",
              {out_valid, req_ready}, 2'b01);
    endtask

    task automatic t_single();    run_burst(22'h000010, 1, -1, 0); endtask
    task automatic t_full_page(); run_burst(22'h12345C, 4, -1, 0); endtask
    task automatic t_same_page(); run_burst(22'h12345D, 3, -1, 0); endtask // R2 again after reopen
    task automatic t_cross();     run_burst(22'h0ABCD2, 7, -1, 0); endtask
    task automatic t_wrap();      run_burst(22'h3FFFFE, 4, -1, 0); endtask // R4 wrap
    task automatic t_stall();     run_burst(22'h200001, 6, 2, 15); endtask

    task automatic t_zero();
        bit quiet = 1;
        @(negedge clk);
        req_addr = 22'h000123; req_len = 8'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (!flash_ce_n || !flash_oe_n || out_valid) quiet = 0;
            @(negedge clk);
        end
        check(quiet, "R9", "zero count stays idle", quiet, 1);
        check(req_ready == 1'b1, "R9", "ready after zero count", req_ready, 1);
    endtask

    bit finished = 0;

    initial begin
        #(200000 * CLK_NS);
        if (!finished) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_full_page();
        t_same_page();
        t_cross();
        t_wrap();
        t_stall();
        t_zero();
        t_single();
        repeat (4) @(negedge clk);
        check(we_bad == 0, "R7", "write enable high", we_bad, 0);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule